// File: doc/BRIEF.md
# Word/Byte Configurable Memory Bus Port

This block is the host-side port of a parallel non-volatile memory emulator. The host drives three active-low strobes (chip enable, output enable, write enable), an address and a 16-bit data bus. A mode input sets the bus width. The port classifies the strobe levels as a read cycle, a write cycle or idle. It moves the cycle into the system clock domain through synchroniser stages and presents a read request or a single-cycle write request to the emulator core. The core sees 16-bit words and byte-lane enables.

With the mode input high the bus is sixteen bits wide. With it low, only the low eight pins carry data. Pins 8 to 14 are released, and pin 15 becomes an extra address input that picks the high or low half of the internal word. The port unpacks the chosen half onto the low pins for reads. For writes, it places the byte on both halves of the write data and marks which half is valid. Per-pin output enables model the tri-state drivers and follow the raw strobes combinationally.

Top module: `membus_port`

## Requirements
- R1: In word mode (word_mode=1) during a read cycle (ce_n=0, oe_n=0, we_n=1), dq_oe is 16'hFFFF and dq_out equals the 16-bit word the core returns on rd_data for the presented address.
- R2: In byte mode (word_mode=0), dq_oe bits 8 to 15 are never set; during a read cycle only dq_oe bits 0 to 7 are set.
- R3: In byte mode, a read returns on dq_out[7:0] bits 7:0 of rd_data when dq_in[15]=0 and bits 15:8 when dq_in[15]=1, and dq_out[15:8] is 0.
- R4: A write cycle (ce_n=0, we_n=0, oe_n=1) yields exactly one wr_req pulse of one clock. The pulse is high in the cycle that begins at the third rising clock edge after the strobes leave the write state.
- R5: A word-mode write presents wr_addr equal to addr_in, wr_data equal to dq_in and wr_be equal to 2'b11.
- R6: A byte-mode write presents wr_addr equal to addr_in and wr_data with dq_in[7:0] in both halves. wr_be is 2'b01 when dq_in[15]=0 and 2'b10 when dq_in[15]=1.
- R7: dq_oe is 0 whenever ce_n is high, oe_n is high or we_n is low.
- R8: With we_n and oe_n both low, no read request, no write request and no output enable arise.
- R9: rd_req is high from the second rising clock edge after a read cycle begins, for as long as the cycle lasts, with rd_addr equal to addr_in. It is low when no read cycle is present.
- R10: After reset, rd_req and wr_req are low and dq_out is 0.
- R11: When data pins change during a write cycle, the write carries the values present last before the strobes end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| word_mode | input | 1 | 1 selects the 16-bit bus, 0 selects the 8-bit bus |
| addr_in | input | AW | Host word address |
| dq_in | input | 16 | Data pins, input side |
| dq_out | output | 16 | Data pins, output side |
| dq_oe | output | 16 | Per-pin output enables |
| rd_req | output | 1 | Read request to the core |
| rd_addr | output | AW | Read word address |
| rd_data | input | 16 | Word returned by the core for rd_addr |
| wr_req | output | 1 | Single-cycle write request |
| wr_addr | output | AW | Write word address |
| wr_data | output | 16 | Write data |
| wr_be | output | 2 | Write byte-lane enables, bit 1 is the high byte |

## Verification
The output enables are combinational, so the bench checks them half a clock after it sets the strobes. rd_req is checked low one cycle after a read begins and high one cycle later. dq_out is checked on the fourth falling edge, after one further register stage. Each expected write is queued together with the cycle number in which its pulse is due: three rising edges after the strobes release. The monitor compares both the payload and that cycle number whenever wr_req appears, and reports any pulse that arrives with no write queued.

// File: rtl/membus_pkg.sv
package membus_pkg;
  localparam int DQ_W   = 16;
  localparam int BYTE_W = 8;
  localparam int LANES  = DQ_W / BYTE_W;

  typedef logic [LANES-1:0] lane_mask_t;

  typedef enum logic [1:0] {
    BUS_IDLE     = 2'd0,
    BUS_READ     = 2'd1,
    BUS_WRITE    = 2'd2,
    BUS_CONFLICT = 2'd3
  } bus_cycle_e;

  // Strobe classification; all strobes active low.
  function automatic bus_cycle_e classify(input logic ce_n, input logic oe_n, input logic we_n);
    bus_cycle_e c;
    if (ce_n)                c = BUS_IDLE;
    else if (!oe_n && !we_n) c = BUS_CONFLICT;
    else if (!oe_n)          c = BUS_READ;
    else if (!we_n)          c = BUS_WRITE;
    else                     c = BUS_IDLE;
    return c;
  endfunction
endpackage

// File: rtl/membus_sync.sv
module membus_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [STAGES-1:0][W-1:0] pipe_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign pipe_d[s] = d;
      end else begin : g_next
        assign pipe_d[s] = pipe_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/membus_rd_fmt.sv
module membus_rd_fmt
  import membus_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_act,
  input  logic            word_mode,
  input  logic            byte_hi,
  input  logic [DQ_W-1:0] rd_data,
  output logic [DQ_W-1:0] dq_out
);
  logic [DQ_W-1:0] out_q;
  logic [DQ_W-1:0] out_d;
  logic [BYTE_W-1:0] lane_sel;

  always_comb begin
    lane_sel = byte_hi ? rd_data[DQ_W-1:BYTE_W] : rd_data[BYTE_W-1:0];
    out_d    = out_q;
    if (rd_act) begin
      if (word_mode) out_d = rd_data;
      else           out_d = {{(DQ_W-BYTE_W){1'b0}}, lane_sel};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign dq_out = out_q;
endmodule

// File: rtl/membus_wr_cap.sv
module membus_wr_cap
  import membus_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_act,
  input  logic            word_mode,
  input  logic [AW-1:0]   addr,
  input  logic [DQ_W-1:0] dq,
  output logic            wr_req,
  output logic [AW-1:0]   wr_addr,
  output logic [DQ_W-1:0] wr_data,
  output lane_mask_t      wr_be
);
  logic            act_prev_q;
  logic            hold_wm_q,   hold_wm_d;
  logic [AW-1:0]   hold_addr_q, hold_addr_d;
  logic [DQ_W-1:0] hold_dq_q,   hold_dq_d;
  logic            req_q, req_d;
  logic [AW-1:0]   oaddr_q, oaddr_d;
  logic [DQ_W-1:0] odata_q, odata_d;
  lane_mask_t      obe_q, obe_d;
  logic            strobe_end;

  always_comb begin
    strobe_end  = act_prev_q & ~wr_act;
    hold_wm_d   = hold_wm_q;
    hold_addr_d = hold_addr_q;
    hold_dq_d   = hold_dq_q;
    if (wr_act) begin
      hold_wm_d   = word_mode;
      hold_addr_d = addr;
      hold_dq_d   = dq;
    end
    req_d   = strobe_end;
    oaddr_d = oaddr_q;
    odata_d = odata_q;
    obe_d   = obe_q;
    if (strobe_end) begin
      oaddr_d = hold_addr_q;
      if (hold_wm_q) begin
        odata_d = hold_dq_q;
        obe_d   = '1;
      end else begin
        odata_d = {LANES{hold_dq_q[BYTE_W-1:0]}};
        obe_d   = hold_dq_q[DQ_W-1] ? lane_mask_t'(2'b10) : lane_mask_t'(2'b01);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_prev_q  <= 1'b0;
      hold_wm_q   <= 1'b1;
      hold_addr_q <= '0;
      hold_dq_q   <= '0;
      req_q       <= 1'b0;
      oaddr_q     <= '0;
      odata_q     <= '0;
      obe_q       <= '0;
    end else begin
      act_prev_q  <= wr_act;
      hold_wm_q   <= hold_wm_d;
      hold_addr_q <= hold_addr_d;
      hold_dq_q   <= hold_dq_d;
      req_q       <= req_d;
      oaddr_q     <= oaddr_d;
      odata_q     <= odata_d;
      obe_q       <= obe_d;
    end
  end

  assign wr_req  = req_q;
  assign wr_addr = oaddr_q;
  assign wr_data = odata_q;
  assign wr_be   = obe_q;
endmodule

// File: rtl/membus_port.sv
module membus_port
  import membus_pkg::*;
#(
  parameter int AW          = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          word_mode,
  input  logic [AW-1:0] addr_in,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  output logic [15:0]   dq_oe,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [15:0]   rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   wr_data,
  output logic [1:0]    wr_be
);
  localparam int BUNDLE_W = 3 + AW + DQ_W;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  bus_cycle_e cyc_raw;
  logic       rd_raw, wr_raw;
  assign cyc_raw = classify(ce_n, oe_n, we_n);
  assign rd_raw  = (cyc_raw == BUS_READ);
  assign wr_raw  = (cyc_raw == BUS_WRITE);

  // Tri-state drive model: pins grouped as low byte, released middle, top pin.
  generate
    for (genvar p = 0; p < DQ_W; p++) begin : g_pin
      if (p < BYTE_W) begin : g_low
        assign dq_oe[p] = rd_raw;
      end else begin : g_upper
        assign dq_oe[p] = rd_raw & word_mode;
      end
    end
  endgenerate

  logic [BUNDLE_W-1:0] bundle_raw, bundle_s;
  logic                rd_s, wr_s, wm_s;
  logic [AW-1:0]       addr_s;
  logic [DQ_W-1:0]     dq_s;

  assign bundle_raw = {rd_raw, wr_raw, word_mode, addr_in, dq_in};

  membus_sync #(.W(BUNDLE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (bundle_raw),
    .q     (bundle_s)
  );

  assign {rd_s, wr_s, wm_s, addr_s, dq_s} = bundle_s;

  assign rd_req  = rd_s;
  assign rd_addr = addr_s;

  membus_rd_fmt u_rd (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rd_act    (rd_s),
    .word_mode (wm_s),
    .byte_hi   (dq_s[DQ_W-1]),
    .rd_data   (rd_data),
    .dq_out    (dq_out)
  );

  membus_wr_cap #(.AW(AW)) u_wr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_act    (wr_s),
    .word_mode (wm_s),
    .addr      (addr_s),
    .dq        (dq_s),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_be     (wr_be)
  );
endmodule

// File: rtl/membus_port_chk.sv
module membus_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ce_n,
  input logic        oe_n,
  input logic        we_n,
  input logic        word_mode,
  input logic [15:0] dq_oe,
  input logic        rd_req,
  input logic        wr_req,
  input logic [15:0] wr_data,
  input logic [1:0]  wr_be
);
  a_r2_upper_released: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |-> (dq_oe[15:8] == 8'h00));

  a_r7_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> (dq_oe == 16'h0000));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);

  a_r6_lane_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_be != 2'b00));

  a_r6_byte_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_be != 2'b11) |-> ($onehot0(wr_be) && wr_data[15:8] == wr_data[7:0]));

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));
endmodule

bind membus_port membus_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .word_mode (word_mode),
  .dq_oe     (dq_oe),
  .rd_req    (rd_req),
  .wr_req    (wr_req),
  .wr_data   (wr_data),
  .wr_be     (wr_be)
);

// File: tb/membus_port_tb.sv
module membus_port_tb;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, we_n, word_mode;
  logic [AW-1:0] addr_in;
  logic [15:0]   dq_in;
  logic [15:0]   dq_out, dq_oe;
  logic          rd_req, wr_req;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [15:0]   rd_data, wr_data;
  logic [1:0]    wr_be;

  always #10 clk = ~clk;

  membus_port #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .word_mode(word_mode), .addr_in(addr_in), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be)
  );

  function automatic logic [15:0] mem_f(input logic [AW-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'hC35A;
  endfunction
  assign rd_data = mem_f(rd_addr);

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [AW-1:0] addr;
    logic [15:0]   data;
    logic [1:0]    be;
    int            due;
  } wr_item_t;
  wr_item_t exp_q[$];

  // Monitor: every write pulse must match the queue front in payload and cycle.
  always @(negedge clk) begin
    if (rst_n && wr_req) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected write", {12'h0, wr_addr}, 32'h0);
      end else begin
        wr_item_t it;
        it = exp_q.pop_front();
        chk(wr_addr == it.addr, "R5/R6 wr_addr", {12'h0, wr_addr}, {12'h0, it.addr});
        chk(wr_data == it.data, "R5/R6/R11 wr_data", {16'h0, wr_data}, {16'h0, it.data});
        chk(wr_be == it.be, "R5/R6 wr_be", {30'h0, wr_be}, {30'h0, it.be});
        chk(cyc == it.due, "R4 pulse cycle", cyc, it.due);
      end
    end
  end

  task automatic idle_bus();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d_first,
                          input logic [15:0] d_last, input bit byte_mode, input bit hi);
    wr_item_t it;
    @(negedge clk);
    word_mode = !byte_mode;
    addr_in   = a;
    dq_in     = byte_mode ? {hi, 7'h00, d_first[7:0]} : d_first;
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    chk(dq_oe == 16'h0, "R7 oe during write", {16'h0, dq_oe}, 32'h0);
    repeat (2) @(negedge clk);
    dq_in = byte_mode ? {hi, 7'h00, d_last[7:0]} : d_last;
    repeat (3) @(negedge clk);
    it.addr = a;
    it.data = byte_mode ? {d_last[7:0], d_last[7:0]} : d_last;
    it.be   = byte_mode ? (hi ? 2'b10 : 2'b01) : 2'b11;
    it.due  = cyc + 3;
    exp_q.push_back(it);
    idle_bus();
    repeat (6) @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit byte_mode, input bit hi);
    logic [15:0] w, exp_out, exp_oe;
    w       = mem_f(a);
    exp_out = byte_mode ? {8'h00, (hi ? w[15:8] : w[7:0])} : w;
    exp_oe  = byte_mode ? 16'h00FF : 16'hFFFF;
    @(negedge clk);
    word_mode = !byte_mode;
    addr_in   = a;
    dq_in     = byte_mode ? {hi, 15'h0} : 16'h0;
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #1;
    chk(dq_oe == exp_oe, byte_mode ? "R2 oe byte read" : "R1 oe word read", {16'h0, dq_oe}, {16'h0, exp_oe});
    @(negedge clk);
    chk(rd_req == 1'b0, "R9 rd_req early", {31'h0, rd_req}, 32'h0);
    @(negedge clk);
    chk(rd_req == 1'b1, "R9 rd_req due", {31'h0, rd_req}, 32'h1);
    chk(rd_addr == a, "R9 rd_addr", {12'h0, rd_addr}, {12'h0, a});
    repeat (2) @(negedge clk);
    chk(dq_out == exp_out, byte_mode ? "R3 byte read data" : "R1 word read data",
        {16'h0, dq_out}, {16'h0, exp_out});
    idle_bus();
    repeat (3) @(negedge clk);
    chk(rd_req == 1'b0, "R9 rd_req after", {31'h0, rd_req}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    idle_bus();
    word_mode = 1'b1;
    addr_in   = '0;
    dq_in     = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(rd_req == 1'b0, "R10 rd_req", {31'h0, rd_req}, 32'h0);
    chk(wr_req == 1'b0, "R10 wr_req", {31'h0, wr_req}, 32'h0);
    chk(dq_out == 16'h0, "R10 dq_out", {16'h0, dq_out}, 32'h0);
    chk(dq_oe == 16'h0, "R7 oe idle", {16'h0, dq_oe}, 32'h0);

    do_read(20'h01234, 1'b0, 1'b0);
    do_read(20'hFEDCB, 1'b0, 1'b0);
    do_read(20'h0A5F0, 1'b1, 1'b0);
    do_read(20'h0A5F0, 1'b1, 1'b1);
    do_read(20'h80001, 1'b1, 1'b1);

    do_write(20'h00010, 16'hBEEF, 16'hBEEF, 1'b0, 1'b0);
    do_write(20'hABCDE, 16'h1111, 16'h7E81, 1'b0, 1'b0); // R11 late data
    do_write(20'h00200, 16'h00C4, 16'h00C4, 1'b1, 1'b0);
    do_write(20'h00201, 16'h0033, 16'h0096, 1'b1, 1'b1); // R11 in byte mode

    // R8: write and output enable low together
    @(negedge clk);
    word_mode = 1'b1;
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(rd_req == 1'b0, "R8 no read", {31'h0, rd_req}, 32'h0);
      chk(dq_oe == 16'h0, "R8 no drive", {16'h0, dq_oe}, 32'h0);
    end
    idle_bus();
    repeat (6) @(negedge clk);

    // R7: output enable low, chip not selected
    oe_n = 1'b0;
    #1;
    chk(dq_oe == 16'h0, "R7 oe chip off", {16'h0, dq_oe}, 32'h0);
    repeat (4) @(negedge clk);
    chk(rd_req == 1'b0, "R9 no read chip off", {31'h0, rd_req}, 32'h0);
    idle_bus();

    // R2: byte mode, read strobes with the top pin high, upper enables stay off
    @(negedge clk);
    word_mode = 1'b0; dq_in = 16'hFFFF; ce_n = 1'b0; oe_n = 1'b0;
    #1;
    chk(dq_oe[15:8] == 8'h00, "R2 upper released", {24'h0, dq_oe[15:8]}, 32'h0);
    idle_bus();
    repeat (6) @(negedge clk);

    chk(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule